// File: doc/BRIEF.md
# Sensor-Indexed Adaptive Operating-Point Controller

This block picks a supply-voltage request, a body-bias code and a clock-frequency request for a processor core from three quantized sensor readings: temperature, supply droop and current draw. The three readings are joined into one index. That index selects an entry in a writable table of precharacterized operating points.

A new index first has to survive a programmable stability filter. The block then moves from the present operating point to the new one through a fixed sequence of steps, with a programmable settle timer after each step. The order keeps the clock from ever outrunning the supply and the bias:

- When the target frequency is equal or higher, the order is voltage, then bias, then frequency.
- When the target frequency is lower, the order is frequency, then bias, then voltage.

A droop reading at its highest code is treated as an emergency. The clock request drops to zero on the next edge, and any sequence in flight is abandoned. Once the droop clears, the block re-applies a table entry.

The body-bias code is two's complement at 32 mV per LSB. Negative values are reverse bias and positive values are forward bias. The table and the four timing/filter settings are written at run time through simple write ports, which sit behind a serial configuration path elsewhere in the chip.

Top module: `opc_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, volt_req is 0xC0, bias_code is 0, freq_req is 0 and busy is 0. The settle times reset to 4 (voltage), 3 (bias) and 2 (frequency), and the stability count resets to 3.
- R2: The table index is {temp_code, droop_code, load_code}, with temp_code in the top bits. A table write with tbl_we high stores {tbl_volt, tbl_bias, tbl_freq} at tbl_addr on that rising edge. Once a sequence completes, the three outputs equal the entry for its index.
- R3: A new index starts a sequence only after it has been sampled unchanged on N+2 consecutive rising edges, where N is the stability count. busy goes high on that last edge. An index that changes back sooner starts nothing.
- R4: When the target frequency is greater than or equal to the present freq_req, volt_req changes first, bias_code second and freq_req last. freq_req is never raised before volt_req and bias_code hold their target values.
- R5: When the target frequency is below the present freq_req, freq_req changes first, bias_code second and volt_req last.
- R6: The first knob changes one edge after busy rises. Each later knob changes T+2 edges after the previous one, where T is the previous knob's settle time. busy falls T+1 edges after the last knob changes, with T being the last knob's settle time.
- R7: While busy, index changes are deferred and table writes do not alter the target in flight.
- R8: droop_code equal to 3 (all ones) forces freq_req to 0 and busy to 0 on the next edge and leaves volt_req and bias_code unchanged. No sequence starts while it persists. After it clears, the next stable index is applied even if it equals the last applied one.
- R9: cfg_we writes cfg_data to a setting chosen by cfg_addr: 0 is the voltage settle time, 1 the bias settle time, 2 the frequency settle time, 3 the stability count N.
- R10: At most one of volt_req, bias_code and freq_req changes on any edge.
- R11: A stable index equal to the last applied index starts no sequence unless a droop emergency has occurred since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_code | input | 2 | Quantized temperature reading |
| droop_code | input | 2 | Quantized supply-droop reading; 3 is an emergency |
| load_code | input | 2 | Quantized current-draw reading |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 6 | Table write index |
| tbl_volt | input | 8 | Voltage code to store |
| tbl_bias | input | 6 | Body-bias code to store (signed, 32 mV/LSB) |
| tbl_freq | input | 8 | Frequency code to store |
| cfg_we | input | 1 | Setting write enable |
| cfg_addr | input | 2 | Setting select |
| cfg_data | input | 8 | Setting value |
| volt_req | output | 8 | Supply-voltage request to the regulator |
| bias_code | output | 6 | Body-bias code to the bias generators |
| freq_req | output | 8 | Frequency request to the clock unit |
| busy | output | 1 | High while a transition sequence runs |

## Verification
The hardest situations to reach are a droop emergency landing in the middle of a sequence, and a table rewrite or index change arriving while a sequence is in flight. The bench reaches both by changing droop_code, the table and the index at chosen cycles, counted from the start of a sequence. A behavioural model built on a run-length count and a queue of pending knob steps predicts every output on every clock. Directed checks follow the knob order of rising and falling moves, a single-cycle glitch, a larger stability count, and zero settle times.

// File: rtl/opc_pkg.sv
package opc_pkg;

    localparam int TEMP_W   = 2;
    localparam int DROOP_W  = 2;
    localparam int LOAD_W   = 2;
    localparam int IDX_W    = TEMP_W + DROOP_W + LOAD_W;
    localparam int VOLT_W   = 8;
    localparam int BIAS_W   = 6;
    localparam int FREQ_W   = 8;
    localparam int TMR_W    = 8;

    localparam logic [VOLT_W-1:0] VOLT_RST = 8'hC0;
    localparam logic [TMR_W-1:0]  DEF_TV   = 8'd4;
    localparam logic [TMR_W-1:0]  DEF_TB   = 8'd3;
    localparam logic [TMR_W-1:0]  DEF_TF   = 8'd2;
    localparam logic [TMR_W-1:0]  DEF_STAB = 8'd3;

    typedef struct packed {
        logic [VOLT_W-1:0] volt;
        logic [BIAS_W-1:0] bias;
        logic [FREQ_W-1:0] freq;
    } op_point_t;

    typedef enum logic [1:0] {KNOB_VOLT, KNOB_BIAS, KNOB_FREQ} knob_e;
    typedef enum logic [1:0] {PH_IDLE, PH_APPLY, PH_WAIT} phase_e;

    typedef struct packed {
        logic [TMR_W-1:0] t_volt;
        logic [TMR_W-1:0] t_bias;
        logic [TMR_W-1:0] t_freq;
        logic [TMR_W-1:0] stab_n;
    } ctl_cfg_t;

    // Which knob a step of the sequence touches, given the direction.
    function automatic knob_e step_knob(input logic up, input logic [1:0] step);
        knob_e k;
        case (step)
            2'd0:    k = up ? KNOB_VOLT : KNOB_FREQ;
            2'd1:    k = KNOB_BIAS;
            default: k = up ? KNOB_FREQ : KNOB_VOLT;
        endcase
        return k;
    endfunction

    function automatic logic droop_severe(input logic [DROOP_W-1:0] d);
        return &d;
    endfunction

endpackage

// File: rtl/opc_table.sv
module opc_table
    import opc_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  op_point_t     wdata,
    input  logic [IW-1:0] raddr,
    output op_point_t     rdata
);
    localparam int DEPTH = 1 << IW;

    op_point_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R2: a write is visible at its address on the following cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/opc_stab.sv
module opc_stab
    import opc_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int TW = TMR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] idx_i,
    input  logic [TW-1:0] need_i,
    output logic          stable_o,
    output logic [IW-1:0] cand_o
);
    logic [IW-1:0] cand;
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cand <= '0;
            cnt  <= '0;
        end else if (idx_i != cand) begin
            cand <= idx_i;
            cnt  <= '0;
        end else if (cnt < need_i) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign stable_o = (idx_i == cand) && (cnt >= need_i);
    assign cand_o   = cand;

    // R3: an index that has just changed is never accepted in that cycle
    a_r3_fresh_index_not_stable: assert property (@(posedge clk) disable iff (rst)
        (idx_i != $past(idx_i)) |-> !stable_o);

endmodule

// File: rtl/opc_seq.sv
module opc_seq
    import opc_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int TW = TMR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stable_i,
    input  logic [IW-1:0] cand_i,
    input  logic          severe_i,
    input  op_point_t     entry_i,
    input  ctl_cfg_t      cfg_i,
    output op_point_t     point_o,
    output logic          busy_o
);
    phase_e        phase;
    logic [1:0]    step;
    logic          up;
    logic [TW-1:0] timer;
    op_point_t     tgt;
    op_point_t     pt;
    logic [IW-1:0] seq_idx;
    logic [IW-1:0] cur_idx;
    logic          resync;

    knob_e         knob;
    logic [TW-1:0] settle;
    logic          want_start;
    logic          last_step;

    always_comb begin
        knob = step_knob(up, step);
        case (knob)
            KNOB_VOLT: settle = cfg_i.t_volt;
            KNOB_BIAS: settle = cfg_i.t_bias;
            default:   settle = cfg_i.t_freq;
        endcase
        last_step  = (step == 2'd2);
        want_start = (phase == PH_IDLE) && stable_i && !severe_i &&
                     (resync || (cand_i != cur_idx));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            step    <= '0;
            up      <= 1'b0;
            timer   <= '0;
            tgt     <= '0;
            seq_idx <= '0;
            cur_idx <= '0;
            resync  <= 1'b1;
            pt      <= '{volt: VOLT_RST, bias: '0, freq: '0};
        end else if (severe_i) begin
            pt.freq <= '0;
            phase   <= PH_IDLE;
            step    <= '0;
            resync  <= 1'b1;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (want_start) begin
                        tgt     <= entry_i;
                        seq_idx <= cand_i;
                        up      <= (entry_i.freq >= pt.freq);
                        step    <= '0;
                        phase   <= PH_APPLY;
                    end
                end
                PH_APPLY: begin
                    case (knob)
                        KNOB_VOLT: pt.volt <= tgt.volt;
                        KNOB_BIAS: pt.bias <= tgt.bias;
                        default:   pt.freq <= tgt.freq;
                    endcase
                    timer <= settle;
                    phase <= PH_WAIT;
                end
                default: begin
                    if (timer == '0) begin
                        if (last_step) begin
                            phase   <= PH_IDLE;
                            cur_idx <= seq_idx;
                            resync  <= 1'b0;
                        end else begin
                            step  <= step + 1'b1;
                            phase <= PH_APPLY;
                        end
                    end else begin
                        timer <= timer - 1'b1;
                    end
                end
            endcase
        end
    end

    assign point_o = pt;
    assign busy_o  = (phase != PH_IDLE);

    // R4: frequency rises only once voltage and bias already hold the target
    a_r4_freq_rise_after_supply: assert property (@(posedge clk) disable iff (rst)
        (pt.freq > $past(pt.freq)) |-> (pt.volt == tgt.volt && pt.bias == tgt.bias));

    // R5: in a downward move voltage drops only after frequency reached target
    a_r5_volt_drop_after_freq: assert property (@(posedge clk) disable iff (rst)
        ((pt.volt < $past(pt.volt)) && !up) |-> (pt.freq == tgt.freq));

    // R10: one knob per edge
    a_r10_one_knob: assert property (@(posedge clk) disable iff (rst)
        $countones({pt.volt != $past(pt.volt), pt.bias != $past(pt.bias),
                    pt.freq != $past(pt.freq)}) <= 1);

    // R8: severe droop drops the clock and aborts the sequence
    a_r8_droop_cuts_freq: assert property (@(posedge clk) disable iff (rst)
        severe_i |=> (pt.freq == '0 && phase == PH_IDLE));

    // R7: the target in flight is frozen while busy
    a_r7_target_frozen: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && !severe_i) |=> $stable(tgt));

endmodule

// File: rtl/opc_ctrl.sv
module opc_ctrl
    import opc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [TEMP_W-1:0]  temp_code,
    input  logic [DROOP_W-1:0] droop_code,
    input  logic [LOAD_W-1:0]  load_code,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_addr,
    input  logic [VOLT_W-1:0]  tbl_volt,
    input  logic [BIAS_W-1:0]  tbl_bias,
    input  logic [FREQ_W-1:0]  tbl_freq,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [TMR_W-1:0]   cfg_data,
    output logic [VOLT_W-1:0]  volt_req,
    output logic [BIAS_W-1:0]  bias_code,
    output logic [FREQ_W-1:0]  freq_req,
    output logic               busy
);
    ctl_cfg_t        cfg;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] cand;
    logic             stable;
    logic             severe;
    op_point_t        entry;
    op_point_t        wentry;
    op_point_t        point;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '{t_volt: DEF_TV, t_bias: DEF_TB, t_freq: DEF_TF, stab_n: DEF_STAB};
        end else if (cfg_we) begin
            case (cfg_addr)
                2'd0:    cfg.t_volt <= cfg_data;
                2'd1:    cfg.t_bias <= cfg_data;
                2'd2:    cfg.t_freq <= cfg_data;
                default: cfg.stab_n <= cfg_data;
            endcase
        end
    end

    assign idx    = {temp_code, droop_code, load_code};
    assign severe = droop_severe(droop_code);
    assign wentry = '{volt: tbl_volt, bias: tbl_bias, freq: tbl_freq};

    opc_table #(.IW(IDX_W)) u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (wentry),
        .raddr (cand),
        .rdata (entry)
    );

    opc_stab #(.IW(IDX_W), .TW(TMR_W)) u_stab (
        .clk      (clk),
        .rst      (rst),
        .idx_i    (idx),
        .need_i   (cfg.stab_n),
        .stable_o (stable),
        .cand_o   (cand)
    );

    opc_seq #(.IW(IDX_W), .TW(TMR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .stable_i (stable),
        .cand_i   (cand),
        .severe_i (severe),
        .entry_i  (entry),
        .cfg_i    (cfg),
        .point_o  (point),
        .busy_o   (busy)
    );

    assign volt_req  = point.volt;
    assign bias_code = point.bias;
    assign freq_req  = point.freq;

endmodule

// File: tb/opc_ctrl_test.sv
module opc_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] temp_code = 0, droop_code = 2'd3, load_code = 0;
    logic       tbl_we = 0;
    logic [5:0] tbl_addr = 0;
    logic [7:0] tbl_volt = 0;
    logic [5:0] tbl_bias = 0;
    logic [7:0] tbl_freq = 0;
    logic       cfg_we = 0;
    logic [1:0] cfg_addr = 0;
    logic [7:0] cfg_data = 0;
    logic [7:0] volt_req;
    logic [5:0] bias_code;
    logic [7:0] freq_req;
    logic       busy;

    int checks = 0, errors = 0, cycles = 0;

    opc_ctrl uut (.*);

    always #5 clk = ~clk;

    // table contents the bench loads
    function automatic int fv(int i); return 64 + 3 * i; endfunction
    function automatic int fb(int i); return (5 * i) & 63; endfunction
    function automatic int ff(int i); return (37 * i + 11) & 255; endfunction

    // ---------------- reference model ----------------
    int mt_v[64], mt_b[64], mt_f[64];
    int m_v, m_b, m_f, m_busy, m_resync, m_applied, m_seq;
    int m_tv, m_tb, m_tf, m_need;
    int prev_idx, run, wait_left;
    int tg_v, tg_b, tg_f;
    int pend[$];

    always @(posedge clk) begin
        int idx, k, t;
        if (rst) begin
            for (int i = 0; i < 64; i++) begin mt_v[i] = 0; mt_b[i] = 0; mt_f[i] = 0; end
            m_v = 8'hC0; m_b = 0; m_f = 0; m_busy = 0; m_resync = 1; m_applied = 0;
            m_tv = 4; m_tb = 3; m_tf = 2; m_need = 3;
            prev_idx = 0; run = 1; wait_left = 0; pend.delete();
        end else begin
            idx = temp_code * 16 + droop_code * 4 + load_code;
            if (idx == prev_idx) begin if (run < 100000) run++; end
            else run = 1;
            prev_idx = idx;
            if (droop_code == 2'd3) begin
                m_f = 0; m_busy = 0; m_resync = 1; pend.delete();
            end else if (m_busy != 0) begin
                wait_left--;
                if (wait_left == 0) begin
                    if (pend.size() == 0) begin
                        m_busy = 0; m_applied = m_seq; m_resync = 0;
                    end else begin
                        k = pend.pop_front();
                        if (k == 0) begin m_v = tg_v; t = m_tv; end
                        else if (k == 1) begin m_b = tg_b; t = m_tb; end
                        else begin m_f = tg_f; t = m_tf; end
                        wait_left = (pend.size() == 0) ? t + 1 : t + 2;
                    end
                end
            end else if (run >= m_need + 2 && (idx != m_applied || m_resync != 0)) begin
                m_seq = idx; tg_v = mt_v[idx]; tg_b = mt_b[idx]; tg_f = mt_f[idx];
                pend.delete();
                if (tg_f >= m_f) begin pend.push_back(0); pend.push_back(1); pend.push_back(2); end
                else begin pend.push_back(2); pend.push_back(1); pend.push_back(0); end
                m_busy = 1; wait_left = 1;
            end
            if (cfg_we) begin
                case (cfg_addr)
                    2'd0: m_tv = cfg_data;
                    2'd1: m_tb = cfg_data;
                    2'd2: m_tf = cfg_data;
                    default: m_need = cfg_data;
                endcase
            end
            if (tbl_we) begin
                mt_v[tbl_addr] = tbl_volt; mt_b[tbl_addr] = tbl_bias; mt_f[tbl_addr] = tbl_freq;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // ---------------- per-cycle comparison ----------------
    logic [7:0] p_v, p_f;
    logic [5:0] p_b;
    int last_knob = -1;

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            check(volt_req == m_v[7:0], "R4,R5,R6 volt_req", volt_req, m_v);
            check(bias_code == m_b[5:0], "R2,R6 bias_code", bias_code, m_b);
            check(freq_req == m_f[7:0], "R8,R9 freq_req", freq_req, m_f);
            check(busy == m_busy[0], "R3,R7,R11 busy", busy, m_busy);
            check(((volt_req != p_v) + (bias_code != p_b) + (freq_req != p_f)) <= 1,
                  "R10 knobs per edge", (volt_req != p_v) + (bias_code != p_b) + (freq_req != p_f), 1);
            if (volt_req != p_v) last_knob = 0;
            if (bias_code != p_b) last_knob = 1;
            if (freq_req != p_f) last_knob = 2;
        end
        p_v = volt_req; p_b = bias_code; p_f = freq_req;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic set_idx(input int t, input int d, input int l);
        temp_code = t[1:0]; droop_code = d[1:0]; load_code = l[1:0];
    endtask

    task automatic cfg(input int a, input int v);
        cfg_we = 1; cfg_addr = a[1:0]; cfg_data = v[7:0];
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic expect_entry(input int i, input string req);
        check(volt_req == fv(i), req, volt_req, fv(i));
        check(bias_code == fb(i), req, bias_code, fb(i));
        check(freq_req == ff(i), req, freq_req, ff(i));
    endtask

    initial begin
        int seen;
        repeat (3) @(negedge clk);
        check(volt_req == 8'hC0 && bias_code == 0 && freq_req == 0 && busy == 0,
              "R1 reset outputs", volt_req, 8'hC0);
        rst = 0;
        @(negedge clk);
        check(volt_req == 8'hC0 && freq_req == 0 && busy == 0, "R1 after reset", freq_req, 0);
        // R9 settings (droop held severe during setup)
        cfg(0, 3); cfg(1, 2); cfg(2, 1); cfg(3, 2);
        for (int i = 0; i < 64; i++) begin
            tbl_we = 1; tbl_addr = i[5:0];
            tbl_volt = fv(i)[7:0]; tbl_bias = fb(i)[5:0]; tbl_freq = ff(i)[7:0];
            @(negedge clk);
        end
        tbl_we = 0;
        check(busy == 0, "R8 no start while severe", busy, 0);
        // first move to index 18
        set_idx(1, 0, 2);
        repeat (40) @(negedge clk);
        expect_entry(18, "R2 entry 18 applied");
        // R11: held index, no new sequence
        seen = 0;
        repeat (20) begin @(negedge clk); if (busy) seen = 1; end
        check(seen == 0, "R11 held index idle", seen, 0);
        // upward move to index 5
        set_idx(0, 1, 1);
        repeat (40) @(negedge clk);
        expect_entry(5, "R2 entry 5");
        check(last_knob == 2, "R4 freq last on rise", last_knob, 2);
        // downward move to index 9
        set_idx(0, 2, 1);
        repeat (40) @(negedge clk);
        expect_entry(9, "R2 entry 9");
        check(last_knob == 0, "R5 volt last on fall", last_knob, 0);
        // R3: single-cycle glitch starts nothing
        set_idx(0, 2, 2);
        @(negedge clk);
        set_idx(0, 2, 1);
        seen = 0;
        repeat (15) begin @(negedge clk); if (busy) seen = 1; end
        check(seen == 0, "R3 glitch ignored", seen, 0);
        // R7: index change and table write while busy
        set_idx(2, 0, 1);
        repeat (6) @(negedge clk);
        check(busy == 1, "R7 busy during move", busy, 1);
        set_idx(0, 1, 2);
        tbl_we = 1; tbl_addr = 6'd33; tbl_volt = 8'h11; tbl_bias = 6'h3F; tbl_freq = 8'h01;
        @(negedge clk);
        tbl_we = 0;
        repeat (8) @(negedge clk);
        check(freq_req == ff(33), "R7 target kept", freq_req, ff(33));
        repeat (40) @(negedge clk);
        expect_entry(6, "R7 deferred index applied");
        // R8: emergency in mid sequence, then resync on same index
        set_idx(0, 0, 2);
        repeat (7) @(negedge clk);
        set_idx(0, 3, 2);
        @(negedge clk);
        check(freq_req == 0 && busy == 0, "R8 emergency", freq_req, 0);
        repeat (3) @(negedge clk);
        set_idx(0, 0, 2);
        repeat (40) @(negedge clk);
        expect_entry(2, "R8 resync after droop");
        // R3 with N=5: 5-cycle excursion ignored, longer accepted
        cfg_we = 1; cfg_addr = 2'd3; cfg_data = 8'd5;
        set_idx(3, 0, 0);
        @(negedge clk);
        cfg_we = 0;
        repeat (4) @(negedge clk);
        set_idx(0, 0, 2);
        repeat (20) @(negedge clk);
        set_idx(3, 1, 3);
        repeat (40) @(negedge clk);
        expect_entry(55, "R3 long stable index");
        // R6 with zero settle times
        cfg(0, 0); cfg(1, 0); cfg(2, 0);
        set_idx(1, 2, 0);
        repeat (30) @(negedge clk);
        expect_entry(24, "R6 zero settle");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule